// File: doc/BRIEF.md
# Bidirectional I/O Port with Serial Override

A general-purpose port of `WIDTH` pins. Every pin has a direction bit and an output latch. Both sit on a simple register bus that has separate write and read strobes for the direction register and the data register. Pad inputs pass through a two-flop synchronizer. A data read then returns the latch for output pins and the synchronized pad level for input pins. Because of this, a pin driven high but held low from outside still reads back as 1.

Two pins can be claimed by a serial peripheral. While `rx_en` is high, the receive pin's driver is held off. While `tx_en` is high, the transmit pin's driver is held on and carries `tx_data` in place of the latch. The synchronized receive pin level is always presented on `rx_data`. A port-wide open-drain mode turns every driver into a pull-down only: it enables the driver when the drive value is 0 and releases the pin when the drive value is 1.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset all direction bits and all latch bits are 0, `pad_oe` is all 0, and `rdata` is 0 while no read strobe is high.
- R2: A cycle with `wr_dir` high loads `wdata` into the direction register. While `rd_dir` is high, `rdata` equals the stored direction bits; `rd_dir` has priority over `rd_dat`.
- R3: A cycle with `wr_dat` high loads `wdata` into the latch whatever the direction bits are. The value is driven on `pad_out` as soon as the direction bit is 1.
- R4: In push-pull mode (`od_en`=0) with no override, `pad_oe` equals the direction bits and `pad_out` equals the latch.
- R5: While `rd_dat` is high and `rd_dir` is low, bit i of `rdata` is latch bit i when direction bit i is 1. Otherwise it is the synchronized pad level, which follows a change on `pad_in` two rising edges later.
- R6: While `rx_en` is high, `pad_oe[RX_BIT]` is 0 whatever its direction bit; the other pins are unaffected.
- R7: While `rx_en` is high, the direction bit of pin `RX_BIT` still selects the data-read source: latch when 1, pad level when 0.
- R8: `rx_data` equals the pad level of pin `RX_BIT` delayed by two rising edges, for any direction bit.
- R9: While `tx_en` is high and `od_en` is 0, `pad_oe[TX_BIT]` is 1 and `pad_out[TX_BIT]` equals `tx_data`, whatever its direction bit or latch.
- R10: With `od_en`=1, `pad_out` is all 0 and `pad_oe[i]` is 1 only when pin i is enabled and its drive value is 0. A data read of an output pin with latch 1 returns 1 even when the pad is held low.
- R11: When neither read strobe is high, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_dir | input | 1 | Direction register write strobe |
| wr_dat | input | 1 | Data latch write strobe |
| rd_dir | input | 1 | Direction register read strobe |
| rd_dat | input | 1 | Port data read strobe |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data (combinational) |
| od_en | input | 1 | Port-wide open-drain mode |
| rx_en | input | 1 | Receiver claims pin RX_BIT |
| tx_en | input | 1 | Transmitter claims pin TX_BIT |
| tx_data | input | 1 | Transmit data from the peripheral |
| rx_data | output | 1 | Synchronized receive pin level |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad drive values |
| pad_oe | output | WIDTH | Pad driver enables |

## Verification
The properties assume that `RX_BIT` and `TX_BIT` differ. They also assume that `pad_in` is low while reset is held, because the two-cycle receive-path property compares `rx_data` with pad values sampled during reset. The bench holds every input at 0 through reset. It changes inputs only at falling edges, and it gives each pad change two rising edges before comparing read data. It never asserts both write strobes in the same cycle, since they share `wdata`.

// File: rtl/gpio_port_ovr.sv
`timescale 1ns/1ps
module gpio_port_ovr #(
  parameter int WIDTH  = 8,
  parameter int RX_BIT = 0,
  parameter int TX_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_dat,
  input  logic             rd_dir,
  input  logic             rd_dat,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             od_en,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             tx_data,
  output logic             rx_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  localparam logic [WIDTH-1:0] RX_SEL = WIDTH'(1) << RX_BIT;
  localparam logic [WIDTH-1:0] TX_SEL = WIDTH'(1) << TX_BIT;

  logic [WIDTH-1:0] dir_q, lat_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] drv, oe_pp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_dat) lat_q <= wdata;
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign drv   = tx_en ? ((lat_q & ~TX_SEL) | ({WIDTH{tx_data}} & TX_SEL)) : lat_q;
  assign oe_pp = (dir_q | (tx_en ? TX_SEL : '0)) & ~(rx_en ? RX_SEL : '0);

  assign pad_oe  = od_en ? (oe_pp & ~drv) : oe_pp;
  assign pad_out = od_en ? '0 : drv;
  assign rx_data = sync2_q[RX_BIT];

  assign rdata = rd_dir ? dir_q :
                 rd_dat ? ((dir_q & lat_q) | (~dir_q & sync2_q)) : '0;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
`timescale 1ns/1ps
module gpio_port_ovr_chk #(
  parameter int WIDTH  = 8,
  parameter int RX_BIT = 0,
  parameter int TX_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_dir,
  input logic             rd_dir,
  input logic             rd_dat,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic             od_en,
  input logic             rx_en,
  input logic             tx_en,
  input logic             tx_data,
  input logic             rx_data,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] lat_q
);
  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dir && $past(wr_dir)) |-> rdata == $past(wdata)); // R2
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !tx_en && !od_en) |-> pad_oe == dir_q); // R4
  AST_OUT_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && !rd_dir) |-> ((rdata ^ lat_q) & dir_q) == '0); // R5
  AST_RX_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> !pad_oe[RX_BIT]); // R6
  AST_RX_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data == $past(pad_in[RX_BIT], 2)); // R8
  AST_TX_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !od_en) |-> (pad_oe[TX_BIT] && pad_out[TX_BIT] == tx_data)); // R9
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    od_en |-> (pad_out == '0 && (pad_oe & lat_q & ~(tx_en ? (WIDTH'(1) << TX_BIT) : '0)) == '0)); // R10
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_dir && !rd_dat) |-> rdata == '0); // R11
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.WIDTH(WIDTH), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .rd_dir(rd_dir), .rd_dat(rd_dat),
  .wdata(wdata), .rdata(rdata), .od_en(od_en), .rx_en(rx_en), .tx_en(tx_en),
  .tx_data(tx_data), .rx_data(rx_data), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .dir_q(dir_q), .lat_q(lat_q)
);

// File: tb/test_gpio_port_ovr.sv
`timescale 1ns/1ps
module test_gpio_port_ovr;
  localparam int W = 4;
  localparam int RXB = 0;
  localparam int TXB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_dir = 0, wr_dat = 0, rd_dir = 0, rd_dat = 0;
  logic [W-1:0] wdata = '0, pad_in = '0;
  logic od_en = 0, rx_en = 0, tx_en = 0, tx_data = 0;
  logic [W-1:0] rdata, pad_out, pad_oe;
  logic rx_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_ovr #(.WIDTH(W), .RX_BIT(RXB), .TX_BIT(TXB)) i_gpio_port_ovr (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_dat(wr_dat), .rd_dir(rd_dir),
    .rd_dat(rd_dat), .wdata(wdata), .rdata(rdata), .od_en(od_en), .rx_en(rx_en),
    .tx_en(tx_en), .tx_data(tx_data), .rx_data(rx_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wdir(input logic [W-1:0] v);
    @(negedge clk); wr_dir = 1; wdata = v;
    @(negedge clk); wr_dir = 0;
  endtask

  task automatic wdat(input logic [W-1:0] v);
    @(negedge clk); wr_dat = 1; wdata = v;
    @(negedge clk); wr_dat = 0;
  endtask

  task automatic rd_port(output logic [W-1:0] v);
    rd_dat = 1; #0.5; v = rdata; rd_dat = 0; #0.1;
  endtask

  logic [W-1:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 idle rdata", 32'(rdata), 0);
    rd_dir = 1; #0.5; chk("R1 dir", 32'(rdata), 0); rd_dir = 0;
    od_en = 0; #0.5; chk("R1 latch on pad_out", 32'(pad_out), 0);

    for (int od = 0; od < 2; od++)
      for (int d = 0; d < 16; d++)
        for (int l = 0; l < 16; l++)
          for (int p = 0; p < 16; p++) begin
            @(negedge clk); od_en = od[0]; wr_dir = 1; wdata = d[W-1:0]; pad_in = p[W-1:0];
            @(negedge clk); wr_dir = 0; wr_dat = 1; wdata = l[W-1:0];
            @(negedge clk); wr_dat = 0; rd_dir = 1; #0.5;
            chk("R2 dir readback", 32'(rdata), 32'(d));
            rd_dat = 1; #0.2;
            chk("R2 rd_dir priority", 32'(rdata), 32'(d));
            rd_dir = 0; #0.2;
            chk("R5 read mux", 32'(rdata), 32'(((d & l) | (~d & p)) & 15));
            rd_dat = 0; #0.2;
            chk("R11 idle", 32'(rdata), 0);
            if (od == 0) begin
              chk("R4 oe", 32'(pad_oe), 32'(d));
              chk("R4 out", 32'(pad_out), 32'(l));
            end else begin
              chk("R10 oe", 32'(pad_oe), 32'(d & ~l & 15));
              chk("R10 out", 32'(pad_out), 0);
            end
            chk("R8 rx_data", 32'(rx_data), 32'(p[RXB]));
          end

    od_en = 0; pad_in = 4'b0101;
    wdir(4'b0000); wdat(4'b1010);
    chk("R3 input pins not driven", 32'(pad_oe), 0);
    rd_port(r); chk("R3 input reads pad", 32'(r), 32'(4'b0101));
    wdir(4'b1111);
    chk("R3 latch appears", 32'(pad_out), 32'(4'b1010));
    chk("R3 oe", 32'(pad_oe), 32'(4'b1111));

    wdat(4'b1111); pad_in = 4'b0000; repeat (2) @(negedge clk);
    @(negedge clk); rx_en = 1; #0.5;
    chk("R6 rx pin off", 32'(pad_oe), 32'(4'b1110));
    rd_port(r); chk("R7 dir=1 reads latch", 32'(r[RXB]), 1);
    chk("R8 rx_data pad level", 32'(rx_data), 0);
    wdir(4'b1110); pad_in = 4'b0001; repeat (2) @(negedge clk);
    rd_port(r); chk("R7 dir=0 reads pad", 32'(r[RXB]), 1);
    chk("R8 rx_data dir=0", 32'(rx_data), 1);
    chk("R6 still off", 32'(pad_oe[RXB]), 0);
    rx_en = 0;

    wdir(4'b0000); wdat(4'b0000); pad_in = 4'b0000; repeat (2) @(negedge clk);
    tx_en = 1;
    for (int t = 0; t < 2; t++) begin
      @(negedge clk); tx_data = t[0]; #0.5;
      chk("R9 tx oe", 32'(pad_oe), 32'(4'b0010));
      chk("R9 tx data", 32'(pad_out[TXB]), 32'(t));
      rd_port(r); chk("R9 dir=0 read pad", 32'(r[TXB]), 0);
    end
    od_en = 1; #0.5;
    chk("R10 tx high releases", 32'(pad_oe[TXB]), 0);
    tx_data = 0; #0.5;
    chk("R10 tx low pulls", 32'(pad_oe[TXB]), 1);
    tx_en = 0; tx_data = 0;

    wdir(4'b1111); wdat(4'b1111); pad_in = 4'b0000; repeat (2) @(negedge clk);
    chk("R10 released", 32'(pad_oe), 0);
    rd_port(r); chk("R10 wired-or reads latch", 32'(r), 32'(4'b1111));
    od_en = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule